// File: doc/BRIEF.md
# Cache line refill sequencer

This block brings a full 16-word cache line in from main memory after a miss. It returns the words to the cache in ascending order, starting at the line base. A miss request carries a word address. The sequencer clears the low four bits of that address and then runs a fixed number of memory rounds. Each word or group of words appears on a strobed output bus together with its offset inside the line. A single-cycle done pulse marks the last delivery. A stall counter reports how many cycles the refill took.

Three memory organisations are available, and the `ORG` parameter picks one at elaboration:

- **Narrow:** one word per access.
- **Wide:** four words returned together in one transfer.
- **Interleaved:** four banks whose access latencies overlap, so one latency is followed by four single-word transfers.

The memory is a behavioural model inside the block with a fixed, parameterised access latency. The miss penalty therefore depends only on the organisation.

Top module: `line_refill_seq`

## Requirements
- R1: The line base is the request address with its low 4 bits cleared. Strobes deliver the line in ascending word offset, and `wordOffset` gives the offset of the first word carried. The data for word address A is {~A, A}: the upper half is the bitwise complement of A and the lower half is A. The data for address A + j sits in lane j, at bits j*DATA_W upward.
- R2: A request is accepted only on a clock edge where `missValid` is high and `busy` is low. From the next cycle, `busy` stays high up to and including the done cycle. A request seen while busy, including one in the done cycle, is ignored.
- R3: In narrow mode (ORG_NARROW), cycle n is the n-th cycle after the accepting edge. Word i is strobed alone in cycle 11*(i+1), so the refill lasts 176 cycles.
- R4: In wide mode (ORG_WIDE), words 4r to 4r+3 are strobed together in cycle 11*(r+1), so the refill lasts 44 cycles.
- R5: In interleaved mode (ORG_INTERLEAVED), word 4r+k (bank k) is strobed alone in cycle 14*r+11+k, so the refill lasts 56 cycles.
- R6: `done` is high for exactly one cycle, in the same cycle as the final strobe, which carries the last offset of the line. `busy` is low in the next cycle.
- R7: `stallCycles` is cleared on acceptance and rises by one for each busy cycle. In busy cycle n it reads n-1. After done it holds the penalty (176, 44 or 56) until the next acceptance.
- R8: While reset is asserted, and directly after it, the block is idle: `busy`, `wordValid` and `done` are low and `stallCycles` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| missValid | input | 1 | Miss request |
| missAddr | input | ADDR_W | Word address of the miss |
| busy | output | 1 | Refill in progress |
| wordValid | output | 1 | Data strobe |
| wordOffset | output | 4 | Offset within the line of the first word carried |
| wordData | output | LANES*2*ADDR_W | Returned data, one lane per word (4 lanes in wide mode, else 1) |
| done | output | 1 | Last delivery of the line |
| stallCycles | output | CNT_W | Cycles spent on the current or last refill |

## Verification
All three organisations are compared against one behavioural model on every clock.

- **Late round start:** a refill that started a round one cycle late would place every strobe off the 11- or 14-cycle grid.
- **Bank order:** interleaved delivery that disturbed bank order would break the ascending offsets.
- **Ignored requests:** requests held high with a different address while busy must not move the line base. A design that sampled them would return data from the wrong line.
- **Request in the done cycle:** this request must also be ignored. A design that accepted it would start one cycle early and shift every later strobe.
- **Counter edges:** an off-by-one stall counter shows up at both the start and the end of each refill.

// File: rtl/refill_pkg.sv
package refill_pkg;
  typedef enum logic [1:0] {
    ORG_NARROW,
    ORG_WIDE,
    ORG_INTERLEAVED
  } org_e;

  typedef struct packed {
    logic load;
    logic advance;
    logic count;
  } dp_ctl_t;
endpackage

// File: rtl/refill_ctrl.sv
module refill_ctrl #(
  parameter int LATENCY = 10,
  parameter int XFERS   = 1,
  parameter int ROUNDS  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 missValid,
  output logic                 busy,
  output logic                 wordValid,
  output logic                 done,
  output refill_pkg::dp_ctl_t  ctl
);
  localparam int LAT_W   = $clog2(LATENCY + 1);
  localparam int XFER_W  = $clog2(XFERS + 1);
  localparam int ROUND_W = $clog2(ROUNDS + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_XFER} state_e;

  state_e             state;
  logic [LAT_W-1:0]   latCnt;
  logic [XFER_W-1:0]  xferCnt;
  logic [ROUND_W-1:0] roundCnt;
  logic               lastXfer;
  logic               lastRound;

  assign lastXfer  = (xferCnt == XFER_W'(XFERS - 1));
  assign lastRound = (roundCnt == ROUND_W'(ROUNDS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      latCnt   <= '0;
      xferCnt  <= '0;
      roundCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (missValid) begin
            state    <= ST_WAIT;
            latCnt   <= '0;
            xferCnt  <= '0;
            roundCnt <= '0;
          end
        end
        ST_WAIT: begin
          if (latCnt == LAT_W'(LATENCY - 1)) begin
            state <= ST_XFER;
          end else begin
            latCnt <= latCnt + 1'b1;
          end
        end
        ST_XFER: begin
          if (lastXfer) begin
            xferCnt <= '0;
            if (lastRound) begin
              state <= ST_IDLE;
            end else begin
              roundCnt <= roundCnt + 1'b1;
              latCnt   <= '0;
              state    <= ST_WAIT;
            end
          end else begin
            xferCnt <= xferCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy        = (state != ST_IDLE);
    wordValid   = (state == ST_XFER);
    done        = wordValid && lastXfer && lastRound;
    ctl.load    = (state == ST_IDLE) && missValid;
    ctl.advance = wordValid;
    ctl.count   = busy;
  end
endmodule

// File: rtl/refill_datapath.sv
module refill_datapath #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4,
  parameter int LANES  = 1,
  parameter int CNT_W  = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  refill_pkg::dp_ctl_t         ctl,
  input  logic [ADDR_W-1:0]           missAddr,
  output logic [OFF_W-1:0]            wordOffset,
  output logic [LANES*2*ADDR_W-1:0]   wordData,
  output logic [CNT_W-1:0]            stallCycles
);
  localparam int DATA_W = 2 * ADDR_W;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'((1 << OFF_W) - 1);

  logic [ADDR_W-1:0] baseAddr;
  logic [OFF_W-1:0]  wordPtr;
  logic [CNT_W-1:0]  stallCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr <= '0;
      wordPtr  <= '0;
      stallCnt <= '0;
    end else if (ctl.load) begin
      baseAddr <= missAddr & ALIGN_MASK;
      wordPtr  <= '0;
      stallCnt <= '0;
    end else begin
      if (ctl.advance) wordPtr <= wordPtr + OFF_W'(LANES);
      if (ctl.count)   stallCnt <= stallCnt + 1'b1;
    end
  end

  // Behavioural memory: each word holds its own address and its complement.
  function automatic logic [DATA_W-1:0] memRead(input logic [ADDR_W-1:0] a);
    return {~a, a};
  endfunction

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [ADDR_W-1:0] laneAddr;
    assign laneAddr = baseAddr + ADDR_W'(wordPtr) + ADDR_W'(j);
    assign wordData[j*DATA_W +: DATA_W] = memRead(laneAddr);
  end

  assign wordOffset  = wordPtr;
  assign stallCycles = stallCnt;
endmodule

// File: rtl/line_refill_seq.sv
module line_refill_seq #(
  parameter refill_pkg::org_e ORG = refill_pkg::ORG_NARROW,
  parameter int ADDR_W      = 16,
  parameter int LATENCY     = 10,
  parameter int LINE_WORDS  = 16,
  parameter int GROUP_WORDS = 4,
  localparam int LANES   = (ORG == refill_pkg::ORG_WIDE) ? GROUP_WORDS : 1,
  localparam int XFERS   = (ORG == refill_pkg::ORG_INTERLEAVED) ? GROUP_WORDS : 1,
  localparam int ROUNDS  = LINE_WORDS / (LANES * XFERS),
  localparam int PENALTY = ROUNDS * (LATENCY + XFERS),
  localparam int CNT_W   = $clog2(PENALTY + 1),
  localparam int OFF_W   = $clog2(LINE_WORDS),
  localparam int DATA_W  = 2 * ADDR_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      missValid,
  input  logic [ADDR_W-1:0]         missAddr,
  output logic                      busy,
  output logic                      wordValid,
  output logic [OFF_W-1:0]          wordOffset,
  output logic [LANES*DATA_W-1:0]   wordData,
  output logic                      done,
  output logic [CNT_W-1:0]          stallCycles
);
  refill_pkg::dp_ctl_t ctl;

  refill_ctrl #(
    .LATENCY(LATENCY),
    .XFERS  (XFERS),
    .ROUNDS (ROUNDS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .missValid(missValid),
    .busy     (busy),
    .wordValid(wordValid),
    .done     (done),
    .ctl      (ctl)
  );

  refill_datapath #(
    .ADDR_W(ADDR_W),
    .OFF_W (OFF_W),
    .LANES (LANES),
    .CNT_W (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .missAddr   (missAddr),
    .wordOffset (wordOffset),
    .wordData   (wordData),
    .stallCycles(stallCycles)
  );
endmodule

// File: rtl/refill_checker.sv
module refill_checker #(
  parameter int OFF_W      = 4,
  parameter int CNT_W      = 8,
  parameter int LANES      = 1,
  parameter int LINE_WORDS = 16,
  parameter int PENALTY    = 176
) (
  input logic             clk,
  input logic             rstN,
  input logic             missValid,
  input logic             busy,
  input logic             wordValid,
  input logic             done,
  input logic [OFF_W-1:0] wordOffset,
  input logic [CNT_W-1:0] stallCycles
);
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    missValid && !busy |=> busy && stallCycles == '0);

  assert_hold_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    busy && !done |=> busy);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy && !done);

  assert_done_last_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> wordValid && wordOffset == OFF_W'(LINE_WORDS - LANES));

  assert_strobe_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> busy);

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> stallCycles == CNT_W'($past(stallCycles) + 1'b1));

  assert_penalty_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> stallCycles == CNT_W'(PENALTY));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !missValid |=> $stable(stallCycles));
endmodule

bind line_refill_seq refill_checker #(
  .OFF_W     (OFF_W),
  .CNT_W     (CNT_W),
  .LANES     (LANES),
  .LINE_WORDS(LINE_WORDS),
  .PENALTY   (PENALTY)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .missValid  (missValid),
  .busy       (busy),
  .wordValid  (wordValid),
  .done       (done),
  .wordOffset (wordOffset),
  .stallCycles(stallCycles)
);

// File: tb/line_refill_seq_bench.sv
module line_refill_seq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        missValid = 1'b0;
  logic [15:0] missAddr = '0;

  always #2 clk = ~clk;

  logic [2:0]   busyO, validO, doneO;
  logic [3:0]   offN, offW, offI;
  logic [31:0]  dataN, dataI;
  logic [127:0] dataW;
  logic [7:0]   stallN;
  logic [5:0]   stallW, stallI;

  line_refill_seq #(.ORG(refill_pkg::ORG_NARROW)) u_line_refill_seq (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missAddr(missAddr),
    .busy(busyO[0]), .wordValid(validO[0]), .wordOffset(offN), .wordData(dataN),
    .done(doneO[0]), .stallCycles(stallN));

  line_refill_seq #(.ORG(refill_pkg::ORG_WIDE)) u_line_refill_seq_wide (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missAddr(missAddr),
    .busy(busyO[1]), .wordValid(validO[1]), .wordOffset(offW), .wordData(dataW),
    .done(doneO[1]), .stallCycles(stallW));

  line_refill_seq #(.ORG(refill_pkg::ORG_INTERLEAVED)) u_line_refill_seq_ilv (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missAddr(missAddr),
    .busy(busyO[2]), .wordValid(validO[2]), .wordOffset(offI), .wordData(dataI),
    .done(doneO[2]), .stallCycles(stallI));

  int errors = 0;
  int checks = 0;

  // Reference model, per organisation: lanes, transfers per round, rounds.
  int lat = 10;
  int lanesM[3]  = '{1, 4, 1};
  int xfersM[3]  = '{1, 1, 4};
  int roundsM[3] = '{16, 4, 4};
  string timeTag[3] = '{"R3", "R4", "R5"};
  int ph[3];
  int lastPen[3];
  logic [15:0] base[3];

  function automatic int penOf(int m);
    return roundsM[m] * (lat + xfersM[m]);
  endfunction

  always @(posedge clk) begin
    for (int m = 0; m < 3; m++) begin
      if (!rstN) begin
        ph[m] = 0;
        lastPen[m] = 0;
        base[m] = '0;
      end else if (ph[m] == 0) begin
        if (missValid) begin
          ph[m] = 1;
          base[m] = missAddr & 16'hFFF0;
        end
      end else if (ph[m] == penOf(m)) begin
        ph[m] = 0;
        lastPen[m] = penOf(m);
      end else begin
        ph[m] = ph[m] + 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic checkMode(input int m, input logic [3:0] off, input logic [127:0] data,
                           input int stall);
    int c, per, q, r, k, expOff, expStall;
    bit expValid, expDone;
    string tb;
    c = ph[m];
    per = lat + xfersM[m];
    expValid = 1'b0;
    expDone = 1'b0;
    expOff = 0;
    if (c > 0) begin
      q = (c - 1) % per;
      r = (c - 1) / per;
      if (q >= lat) begin
        k = q - lat;
        expValid = 1'b1;
        expOff = r * lanesM[m] * xfersM[m] + k * lanesM[m];
        expDone = (c == penOf(m));
      end
    end
    expStall = (c > 0) ? c - 1 : lastPen[m];
    tb = (!rstN) ? "R8" : "R2";
    check(busyO[m] == (c > 0), tb, longint'(busyO[m]), longint'(c > 0));
    tb = (!rstN) ? "R8" : timeTag[m];
    check(validO[m] == expValid, tb, longint'(validO[m]), longint'(expValid));
    check(doneO[m] == expDone, (!rstN) ? "R8" : "R6", longint'(doneO[m]), longint'(expDone));
    check(stall == expStall, (!rstN) ? "R8" : "R7", longint'(stall), longint'(expStall));
    if (expValid && validO[m]) begin
      check(off == 4'(expOff), "R1", longint'(off), longint'(expOff));
      for (int j = 0; j < lanesM[m]; j++) begin
        logic [15:0] a;
        a = base[m] + 16'(expOff) + 16'(j);
        check(data[j*32 +: 32] == {~a, a}, "R1", longint'(data[j*32 +: 32]),
              longint'({~a, a}));
      end
    end
  endtask

  always @(negedge clk) begin
    checkMode(0, offN, {96'b0, dataN}, int'(stallN));
    checkMode(1, offW, dataW, int'(stallW));
    checkMode(2, offI, {96'b0, dataI}, int'(stallI));
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(5);
    rstN = 1'b1;
    idle(3);
    // Single request, unaligned address.
    missValid = 1'b1;
    missAddr = 16'h1237;
    idle(1);
    missValid = 1'b0;
    idle(20);
    // Requests held while busy with another address: ignored, then taken when idle.
    missValid = 1'b1;
    missAddr = 16'hABCD;
    idle(100);
    missValid = 1'b0;
    idle(300);
    // Continuous request at the top of memory: back-to-back refills,
    // including a request present in the done cycle.
    missValid = 1'b1;
    missAddr = 16'hFFFF;
    idle(400);
    missValid = 1'b0;
    idle(200);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule